// File: doc/BRIEF.md
# Configurable Logic Cell with Multi-Mode Register

A behavioural model of a single programmable logic cell. The cell holds a 4-input look-up table whose 16-bit truth table is a static configuration input. Its result feeds a one-bit register that can behave as a D, T, JK or SR flip-flop. The register sits behind a set of controls that share one priority order:

- asynchronous clear;
- asynchronous preset or asynchronous load;
- synchronous clear;
- synchronous load;
- the next state for the chosen mode.

All synchronous behaviour is gated by a clock enable. The register clock and the clear are each picked from two shared sources by a select bit. A chip-wide active-low reset also clears the register.

Each of three outputs selects on its own between the combinational LUT result and the register. The LUT and the register can therefore serve unrelated functions, or the cell can present the registered and unregistered copies of one function at once. In feedback mode the register output replaces one LUT input, so the register is packed with its own next-state logic. All configuration inputs are meant to be held static while the cell runs.

Top module: `ple_cell`

## Requirements
- R1: The LUT result equals `lut_mask_i[idx]`, where `idx = data_i` with `data_i[0]` as the least significant bit. An output whose `out_sel_i` bit is 0 shows the LUT result combinationally, with no clock.
- R2: With `reg_mode_i`=0 (D), on a rising edge of the selected clock with `ena_i`=1 and no synchronous control, the register takes the LUT result.
- R3: With `reg_mode_i`=1 (T), the register inverts when the LUT result is 1 and holds when it is 0.
- R4: With `reg_mode_i`=2 (JK), J is the LUT result and K is `data_i[3]`. The pairs behave as follows: 00 holds, 01 clears, 10 sets, 11 inverts.
- R5: With `reg_mode_i`=3 (SR), S is the LUT result and R is `data_i[3]`. The pairs behave as follows: 10 sets, 01 clears, 00 holds, 11 holds.
- R6: With `ena_i`=0, a clock edge changes nothing, and `sclr_i` and `sload_i` have no effect.
- R7: `sclr_i`=1 with `ena_i`=1 clears the register at the clock edge. It wins over `sload_i` and over the mode logic.
- R8: `sload_i`=1 with `ena_i`=1 and `sclr_i`=0 loads `data_i[2]` at the clock edge. It wins over the mode logic.
- R9: The register clears at once, with no clock, when `rst_ni`=0 or when the selected clear is low. The selected clear is `clr_b_ni` if `clr_sel_i`=1, and `clr_a_ni` otherwise. Clear wins over `aload_i`.
- R10: While `aload_i`=1, with no clock, the register becomes 1 if `aload_src_i`=0, or becomes `data_i[2]` if `aload_src_i`=1. Clock edges with synchronous controls do not override this value.
- R11: `clk_sel_i`=1 clocks the register from `clk_b_i`, and 0 clocks it from `clk_a_i`. Edges of the unselected clock, and lows on the unselected clear, have no effect.
- R12: `out_o[i]` shows the register when `out_sel_i[i]`=1 and the LUT result when it is 0. Each output chooses independently.
- R13: With `fb_en_i`=1, LUT input 0 is the register output instead of `data_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Shared clock source A |
| clk_b_i | input | 1 | Shared clock source B |
| clk_sel_i | input | 1 | Clock source select (1 = B) |
| rst_ni | input | 1 | Chip-wide asynchronous reset, active low |
| clr_a_ni | input | 1 | Shared asynchronous clear A, active low |
| clr_b_ni | input | 1 | Shared asynchronous clear B, active low |
| clr_sel_i | input | 1 | Clear source select (1 = B) |
| ena_i | input | 1 | Clock enable |
| aload_i | input | 1 | Asynchronous preset/load strobe, active high |
| aload_src_i | input | 1 | 0 = preset to 1, 1 = load `data_i[2]` |
| sclr_i | input | 1 | Synchronous clear |
| sload_i | input | 1 | Synchronous load of `data_i[2]` |
| data_i | input | 4 | LUT data inputs |
| lut_mask_i | input | 16 | LUT truth table |
| reg_mode_i | input | 2 | Register mode: 0 D, 1 T, 2 JK, 3 SR |
| fb_en_i | input | 1 | Route register into LUT input 0 |
| out_sel_i | input | 3 | Per-output source select (1 = register) |
| out_o | output | 3 | Cell outputs |

## Verification
The bench sweeps every LUT index for several masks. For each of the four register modes it covers both starting states against all 16 data patterns. A mode decoder with swapped J/K roles, or one that lets S=R=1 set or clear, would miss expected values in that sweep.

Priority corners are driven one by one:
- clear together with preset;
- synchronous clear together with synchronous load;
- load against a toggle that would produce the opposite value;
- synchronous controls while clock enable is low.

An inverted priority or a leaky enable would leave the wrong register value. Further cases drive edges on the unselected clock, lows on the unselected clear, and a feedback toggle loop. A crossed select would change the register when it must hold, and dropped feedback would stop the toggle.

// File: rtl/ple_pkg.sv
package ple_pkg;
  typedef enum logic [1:0] {
    REG_D  = 2'd0,
    REG_T  = 2'd1,
    REG_JK = 2'd2,
    REG_SR = 2'd3
  } reg_mode_e;
endpackage

// File: rtl/ple_lut.sv
module ple_lut #(
  parameter int K = 4,
  localparam int MaskW = 1 << K
) (
  input  logic [K-1:0]     sel_i,
  input  logic [MaskW-1:0] mask_i,
  output logic             y_o
);
  assign y_o = mask_i[sel_i];
endmodule

// File: rtl/ple_next_state.sv
module ple_next_state
  import ple_pkg::*;
(
  input  reg_mode_e mode_i,
  input  logic      lut_i,
  input  logic      aux_i,
  input  logic      q_i,
  output logic      nxt_o
);
  always_comb begin
    unique case (mode_i)
      REG_D:  nxt_o = lut_i;
      REG_T:  nxt_o = q_i ^ lut_i;
      REG_JK: begin
        unique case ({lut_i, aux_i})
          2'b00:   nxt_o = q_i;
          2'b01:   nxt_o = 1'b0;
          2'b10:   nxt_o = 1'b1;
          default: nxt_o = ~q_i;
        endcase
      end
      default: begin
        unique case ({lut_i, aux_i})
          2'b10:   nxt_o = 1'b1;
          2'b01:   nxt_o = 1'b0;
          default: nxt_o = q_i; // S=R=1 holds
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ple_reg.sv
module ple_reg (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic aload_i,
  input  logic aload_val_i,
  input  logic ena_i,
  input  logic sclr_i,
  input  logic sload_i,
  input  logic sload_val_i,
  input  logic nxt_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge clr_ni or posedge aload_i) begin
    if (!clr_ni)      q_o <= 1'b0;
    else if (aload_i) q_o <= aload_val_i;
    else if (ena_i) begin
      if (sclr_i)       q_o <= 1'b0;
      else if (sload_i) q_o <= sload_val_i;
      else              q_o <= nxt_i;
    end
  end

  assert_sclr_R7: assert property (@(posedge clk_i) disable iff (!clr_ni || aload_i)
    (ena_i && sclr_i) |=> (q_o == 1'b0));

  assert_sload_R8: assert property (@(posedge clk_i) disable iff (!clr_ni || aload_i)
    (ena_i && !sclr_i && sload_i) |=> (q_o == $past(sload_val_i)));
endmodule

// File: rtl/ple_out_mux.sv
module ple_out_mux #(
  parameter int NumOut = 3
) (
  input  logic [NumOut-1:0] sel_i,
  input  logic              lut_i,
  input  logic              reg_i,
  output logic [NumOut-1:0] out_o
);
  for (genvar i = 0; i < NumOut; i++) begin : g_out
    assign out_o[i] = sel_i[i] ? reg_i : lut_i;
  end
endmodule

// File: rtl/ple_cell.sv
module ple_cell
  import ple_pkg::*;
#(
  parameter int K      = 4,
  parameter int NumOut = 3,
  parameter int FbIdx  = 0,
  parameter int LdIdx  = 2,
  localparam int MaskW  = 1 << K,
  localparam int AuxIdx = K - 1
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              clk_sel_i,
  input  logic              rst_ni,
  input  logic              clr_a_ni,
  input  logic              clr_b_ni,
  input  logic              clr_sel_i,
  input  logic              ena_i,
  input  logic              aload_i,
  input  logic              aload_src_i,
  input  logic              sclr_i,
  input  logic              sload_i,
  input  logic [K-1:0]      data_i,
  input  logic [MaskW-1:0]  lut_mask_i,
  input  logic [1:0]        reg_mode_i,
  input  logic              fb_en_i,
  input  logic [NumOut-1:0] out_sel_i,
  output logic [NumOut-1:0] out_o
);
  logic          cell_clk, clr_n, q, lut_y, nxt, aload_val;
  logic [K-1:0]  lut_in;
  reg_mode_e     mode;

  assign cell_clk  = clk_sel_i ? clk_b_i : clk_a_i;
  assign clr_n     = rst_ni & (clr_sel_i ? clr_b_ni : clr_a_ni);
  assign mode      = reg_mode_e'(reg_mode_i);
  assign aload_val = aload_src_i ? data_i[LdIdx] : 1'b1;

  always_comb begin
    lut_in = data_i;
    if (fb_en_i) lut_in[FbIdx] = q; // packed feedback
  end

  ple_lut #(.K(K)) u_lut (
    .sel_i(lut_in), .mask_i(lut_mask_i), .y_o(lut_y)
  );

  ple_next_state u_ns (
    .mode_i(mode), .lut_i(lut_y), .aux_i(data_i[AuxIdx]), .q_i(q), .nxt_o(nxt)
  );

  ple_reg u_reg (
    .clk_i(cell_clk), .clr_ni(clr_n), .aload_i(aload_i), .aload_val_i(aload_val),
    .ena_i(ena_i), .sclr_i(sclr_i), .sload_i(sload_i),
    .sload_val_i(data_i[LdIdx]), .nxt_i(nxt), .q_o(q)
  );

  ple_out_mux #(.NumOut(NumOut)) u_mux (
    .sel_i(out_sel_i), .lut_i(lut_y), .reg_i(q), .out_o(out_o)
  );

  assert_t_toggle_R3: assert property (@(posedge cell_clk) disable iff (!clr_n || aload_i)
    (mode == REG_T && ena_i && !sclr_i && !sload_i && lut_y) |=> (q == !$past(q)));

  assert_jk_toggle_R4: assert property (@(posedge cell_clk) disable iff (!clr_n || aload_i)
    (mode == REG_JK && ena_i && !sclr_i && !sload_i && lut_y && data_i[AuxIdx])
    |=> (q == !$past(q)));

  assert_sr_hold_R5: assert property (@(posedge cell_clk) disable iff (!clr_n || aload_i)
    (mode == REG_SR && ena_i && !sclr_i && !sload_i && lut_y && data_i[AuxIdx])
    |=> $stable(q));
endmodule

// File: tb/tb_ple_cell.sv
module tb_ple_cell;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk_a = 0, clk_b = 0, clk_sel = 0, rst_n = 0;
  logic clr_a_n = 1, clr_b_n = 1, clr_sel = 0;
  logic ena = 0, aload = 0, aload_src = 0, sclr = 0, sload = 0, fb_en = 0;
  logic [3:0]  data = 0;
  logic [15:0] mask = 0;
  logic [1:0]  mode = 0;
  logic [2:0]  out_sel = 3'b111;
  logic [2:0]  out;

  int checks = 0, errors = 0;

  ple_cell dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .clk_sel_i(clk_sel), .rst_ni(rst_n),
    .clr_a_ni(clr_a_n), .clr_b_ni(clr_b_n), .clr_sel_i(clr_sel), .ena_i(ena),
    .aload_i(aload), .aload_src_i(aload_src), .sclr_i(sclr), .sload_i(sload),
    .data_i(data), .lut_mask_i(mask), .reg_mode_i(mode), .fb_en_i(fb_en),
    .out_sel_i(out_sel), .out_o(out)
  );

  task automatic check(input logic [2:0] exp, input string req);
    checks++;
    if (out !== exp) begin
      errors++;
      $display("FAIL %s: out=%b expected=%b", req, out, exp);
    end
  endtask

  task automatic pulse_a();
    #HALF clk_a = 1; #HALF clk_a = 0; #1;
  endtask

  task automatic pulse_b();
    #HALF clk_b = 1; #HALF clk_b = 0; #1;
  endtask

  task automatic idle();
    ena = 0; sclr = 0; sload = 0; pulse_a();
  endtask

  // register value set through synchronous load, then an idle edge
  task automatic set_q(input logic v);
    ena = 1; sclr = 0; sload = 1; data = {1'b0, v, 2'b00};
    pulse_a();
    sload = 0; ena = 0; pulse_a();
  endtask

  function automatic logic model_next(input logic [1:0] m, input logic l,
                                      input logic a, input logic q);
    case (m)
      2'd0:    return l;
      2'd1:    return q ^ l;
      2'd2:    return (l & ~q) | (~a & q);
      default: return (l & ~a) | (q & ~(~l & a));
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: out=x expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] masks [3];
    masks[0] = 16'hA5C3; masks[1] = 16'h8001; masks[2] = 16'h7E96;
    #3;
    check(3'b000, "R9 reset");
    rst_n = 1; #1;

    // R1 LUT sweep
    out_sel = 3'b000;
    for (int m = 0; m < 3; m++) begin
      mask = masks[m];
      for (int d = 0; d < 16; d++) begin
        data = d[3:0]; #1;
        check({3{mask[d]}}, "R1 lut");
      end
    end

    // R2..R5 mode sweep
    out_sel = 3'b111; mask = 16'h6B1D;
    for (int md = 0; md < 4; md++) begin
      mode = md[1:0];
      for (int q0 = 0; q0 < 2; q0++) begin
        for (int d = 0; d < 16; d++) begin
          logic e;
          set_q(q0[0]);
          data = d[3:0]; ena = 1;
          e = model_next(mode, mask[d], data[3], q0[0]);
          pulse_a();
          case (md)
            0: check({3{e}}, "R2 d mode");
            1: check({3{e}}, "R3 t mode");
            2: check({3{e}}, "R4 jk mode");
            default: check({3{e}}, "R5 sr mode");
          endcase
        end
      end
    end

    // R6 enable low
    mode = 0; mask = 16'h0000;
    set_q(1);
    ena = 0; sclr = 1; pulse_a(); check(3'b111, "R6 sclr ignored");
    sclr = 0; sload = 1; data = 4'b0000; pulse_a(); check(3'b111, "R6 sload ignored");
    sload = 0; pulse_a(); check(3'b111, "R6 d ignored");

    // R7 sclr over sload
    ena = 1; sclr = 1; sload = 1; data = 4'b0100; pulse_a();
    check(3'b000, "R7 sclr priority");
    idle();

    // R8 sload over toggle
    mode = 1; mask = 16'hFFFF;
    set_q(0);
    ena = 1; sload = 1; data = 4'b0000; pulse_a(); check(3'b000, "R8 load 0 over toggle");
    idle();
    set_q(1);
    ena = 1; sload = 1; data = 4'b0100; pulse_a(); check(3'b111, "R8 load 1 over toggle");
    idle();

    // R10 async preset/load
    mode = 0; mask = 16'h0000; ena = 0;
    aload_src = 0; aload = 1; #1; check(3'b111, "R10 preset");
    aload = 0; #1; check(3'b111, "R10 preset retained");
    aload_src = 1; data = 4'b0000; aload = 1; #1; check(3'b000, "R10 load data2=0");
    aload = 0; #1; data = 4'b0100; aload = 1; #1; check(3'b111, "R10 load data2=1");
    ena = 1; sclr = 1; pulse_a(); check(3'b111, "R10 sclr overridden");
    aload = 0; idle(); check(3'b111, "R10 after release");

    // R9 async clear priority
    aload_src = 0; aload = 1; clr_a_n = 0; #1; check(3'b000, "R9 clear over preset");
    aload = 0; #1; clr_a_n = 1; #1;
    aload = 1; #1; aload = 0; #1; check(3'b111, "R9 preset restore");
    rst_n = 0; #1; check(3'b000, "R9 chip reset");
    rst_n = 1; #1;

    // R11 clock and clear selection
    mode = 0; mask = 16'hFFFF; clk_sel = 1; ena = 1;
    pulse_a(); check(3'b000, "R11 clk_a ignored");
    pulse_b(); check(3'b111, "R11 clk_b used");
    ena = 0; pulse_b(); clk_sel = 0;
    clr_sel = 1; clr_a_n = 0; #1; check(3'b111, "R11 clr_a ignored");
    clr_a_n = 1; clr_b_n = 0; #1; check(3'b000, "R11 clr_b used");
    clr_b_n = 1; clr_sel = 0; #1;

    // R12 independent output selects
    aload_src = 0; aload = 1; #1; aload = 0; mask = 16'h0000; #1;
    out_sel = 3'b101; #1; check(3'b101, "R12 mixed sel");
    out_sel = 3'b010; #1; check(3'b010, "R12 mixed sel 2");

    // R13 feedback toggle loop, lut = ~input0
    out_sel = 3'b111; mode = 0; mask = 16'h5555; data = 4'b0000;
    set_q(0);
    fb_en = 1; ena = 1; pulse_a(); check(3'b111, "R13 fb toggle to 1");
    pulse_a(); check(3'b000, "R13 fb toggle to 0");
    pulse_a(); ena = 0; out_sel = 3'b000; #1;
    check(3'b000, "R13 lut sees register");
    fb_en = 0; #1; check(3'b111, "R13 lut sees data");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule